// File: doc/BRIEF.md
# Serial Memory Power-Mode Controller

This block tracks the power mode of a serial flash memory with an SPI-style interface. It watches the active-low chip select, the serial clock and the serial data input, and brings all three into the system clock domain. It collects each frame of 8-bit instructions, most significant bit first, and reports one of three modes: standby, active, or deep power-down. It also drives a command-enable mask that the rest of the device uses to decide which instructions may run.

A deep power-down instruction enters the low-power mode only when three things hold: the frame ends exactly after its eighth bit, no internal write, program or erase cycle is running, and a programmable delay in system clock cycles has expired. In deep power-down the block reports that mode whatever the chip select and busy inputs do, and it blocks every command class. The only instruction it acts on in that mode is the release instruction, framed in the same way. A release that arrives while entry is still counting down cancels the entry.

Top module: `spi_pwr_mode_ctrl`

## Requirements
- R1: After reset `mode` is standby (2'b00) and `cmd_en` is 2'b11. The block never leaves reset in deep power-down.
- R2: Outside deep power-down, `mode` is active (2'b01) while chip select is low or `busy` is high. Otherwise it is standby (2'b00).
- R3: Among the 256 opcode values, only `DP_OPCODE` in a valid frame starts deep power-down entry. Any other opcode leaves the mode unchanged.
- R4: A frame is valid only when chip select rises after exactly 8 serial-clock rising edges. A frame of 0 to 7 bits, or of more than 8 bits, is discarded.
- R5: After a valid entry frame, `mode` reads deep power-down (2'b10) from the (ENTRY_DELAY+3)-th rising clock edge after the chip-select rise. It does not read deep power-down at the (ENTRY_DELAY+2)-th edge.
- R6: In deep power-down, `mode` stays 2'b10 whatever chip select and `busy` do, and `cmd_en` is 2'b00. Bit 1 of `cmd_en` enables write/program/erase; bit 0 enables the other instructions.
- R7: A valid frame holding `REL_OPCODE`, received in deep power-down, returns the block to the mode given by R2 and sets `cmd_en` back to 2'b11.
- R8: In deep power-down, every opcode other than `REL_OPCODE` has no effect, and so does a release frame that is not valid.
- R9: A deep power-down frame received while `busy` is high is rejected. The block never enters deep power-down from that frame, even after `busy` falls.
- R10: A valid release frame received while entry is counting down cancels the entry.
- R11: The bit counter restarts on every falling edge of chip select, so a discarded partial frame does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data input |
| busy | input | 1 | An internal write, program or erase cycle is running |
| mode | output | 2 | 00 standby, 01 active, 10 deep power-down |
| cmd_en | output | 2 | Bit 1 write/program/erase enable, bit 0 other-instruction enable |

## Verification
The bench builds the block with the default opcodes and 8-bit instructions, and sets ENTRY_DELAY to 100. At that delay a full 8-bit release frame fits inside the entry countdown, so R10 can be exercised. At that size the bench can also sweep every one of the 256 opcodes, both in standby and in deep power-down, and sweep frame lengths of 0 to 12 bits. With this delay the bench checks the exact edge on which the mode changes against the (ENTRY_DELAY+3) count.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_STANDBY = 2'b00,
        PM_ACTIVE  = 2'b01,
        PM_DEEP    = 2'b10
    } pm_mode_e;

    localparam logic [1:0] CMD_ALL  = 2'b11;
    localparam logic [1:0] CMD_NONE = 2'b00;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int         WIDTH   = 1,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stg_d[g] = async_i;
        end else begin : g_next
            always_comb stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/pmc_frame.sv
module pmc_frame #(
    parameter int INSTR_BITS = 8,
    localparam int CNT_W     = (INSTR_BITS > 1) ? $clog2(INSTR_BITS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_s,
    input  logic                  sck_s,
    input  logic                  sdi_s,
    output logic                  frame_ok,
    output logic [INSTR_BITS-1:0] opcode
);

    typedef struct packed {
        logic                  cs_n;
        logic                  sck;
        logic [INSTR_BITS-1:0] shreg;
        logic [CNT_W-1:0]      cnt;
        logic                  full;
        logic                  over;
    } frm_t;

    frm_t st_d, st_q;
    logic cs_fall, cs_rise, sck_rise;

    always_comb begin
        cs_fall  = st_q.cs_n & ~cs_n_s;
        cs_rise  = ~st_q.cs_n & cs_n_s;
        sck_rise = ~st_q.sck & sck_s;

        st_d      = st_q;
        st_d.cs_n = cs_n_s;
        st_d.sck  = sck_s;

        if (cs_fall) begin
            st_d.cnt  = '0;
            st_d.full = 1'b0;
            st_d.over = 1'b0;
        end else if (!cs_n_s && sck_rise) begin
            if (st_q.full) begin
                st_d.over = 1'b1;
            end else begin
                st_d.shreg = {st_q.shreg[INSTR_BITS-2:0], sdi_s};
                if (st_q.cnt == CNT_W'(INSTR_BITS - 1)) begin
                    st_d.full = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_ok = cs_rise & st_q.full & ~st_q.over;
    assign opcode   = st_q.shreg;

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (st_q.cnt == '0 && !st_q.full && !st_q.over)); // R11

    AST_NO_FRAME_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_s |-> !frame_ok); // R4

endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
#(
    parameter int                  INSTR_BITS  = 8,
    parameter int                  ENTRY_DELAY = 16,
    parameter logic [INSTR_BITS-1:0] DP_OPCODE  = 8'hB9,
    parameter logic [INSTR_BITS-1:0] REL_OPCODE = 8'hAB,
    localparam int                 DLY_W = $clog2(ENTRY_DELAY + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_ok,
    input  logic [INSTR_BITS-1:0] opcode,
    input  logic                  cs_n_s,
    input  logic                  busy,
    output pm_mode_e              mode,
    output logic [1:0]            cmd_en
);

    typedef struct packed {
        logic             deep;
        logic             pend;
        logic [DLY_W-1:0] cnt;
    } fsm_t;

    fsm_t st_d, st_q;
    logic dp_hit, rel_hit;

    always_comb begin
        dp_hit  = frame_ok && (opcode == DP_OPCODE);
        rel_hit = frame_ok && (opcode == REL_OPCODE);

        st_d = st_q;
        if (st_q.deep) begin
            if (rel_hit) st_d.deep = 1'b0;
        end else if (st_q.pend) begin
            if (rel_hit) begin
                st_d.pend = 1'b0;
                st_d.cnt  = '0;
            end else if (st_q.cnt == '0) begin
                st_d.deep = 1'b1;
                st_d.pend = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (dp_hit && !busy) begin
            st_d.pend = 1'b1;
            st_d.cnt  = DLY_W'(ENTRY_DELAY - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.deep) begin
            mode   = PM_DEEP;
            cmd_en = CMD_NONE;
        end else begin
            mode   = (!cs_n_s || busy) ? PM_ACTIVE : PM_STANDBY;
            cmd_en = CMD_ALL;
        end
    end

    AST_BUSY_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_hit && busy && !st_q.pend) |=> !st_q.pend); // R9

    AST_ENTRY_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.deep) |-> $past(st_q.pend)); // R5

    AST_EXIT_BY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.deep) |-> $past(rel_hit)); // R7

    AST_DEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.deep && !rel_hit) |=> (mode == PM_DEEP)); // R8

    AST_CANCEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && rel_hit) |=> (!st_q.pend && !st_q.deep)); // R10

    AST_STATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.deep && st_q.pend)); // R3

endmodule

// File: rtl/spi_pwr_mode_ctrl.sv
module spi_pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int                  INSTR_BITS  = 8,
    parameter int                  ENTRY_DELAY = 16,
    parameter int                  SYNC_STAGES = 2,
    parameter logic [INSTR_BITS-1:0] DP_OPCODE  = 8'hB9,
    parameter logic [INSTR_BITS-1:0] REL_OPCODE = 8'hAB
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       sdi,
    input  logic       busy,
    output logic [1:0] mode,
    output logic [1:0] cmd_en
);

    localparam int NSIG = 3;

    logic [NSIG-1:0]       pins_s;
    logic                  frame_ok;
    logic [INSTR_BITS-1:0] opcode;
    pm_mode_e              mode_e;

    pmc_sync #(
        .WIDTH   (NSIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sck, sdi}),
        .sync_o  (pins_s)
    );

    pmc_frame #(
        .INSTR_BITS (INSTR_BITS)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s[2]),
        .sck_s    (pins_s[1]),
        .sdi_s    (pins_s[0]),
        .frame_ok (frame_ok),
        .opcode   (opcode)
    );

    pmc_mode_fsm #(
        .INSTR_BITS  (INSTR_BITS),
        .ENTRY_DELAY (ENTRY_DELAY),
        .DP_OPCODE   (DP_OPCODE),
        .REL_OPCODE  (REL_OPCODE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_ok (frame_ok),
        .opcode   (opcode),
        .cs_n_s   (pins_s[2]),
        .busy     (busy),
        .mode     (mode_e),
        .cmd_en   (cmd_en)
    );

    assign mode = mode_e;

endmodule

// File: tb/spi_pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module spi_pwr_mode_ctrl_tb;

    localparam int DLY = 100;
    localparam logic [7:0] DP  = 8'hB9;
    localparam logic [7:0] REL = 8'hAB;
    localparam logic [1:0] M_SB = 2'b00, M_ACT = 2'b01, M_DEEP = 2'b10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, busy = 1'b0;
    logic [1:0] mode, cmd_en;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_pwr_mode_ctrl #(
        .ENTRY_DELAY (DLY),
        .DP_OPCODE   (DP),
        .REL_OPCODE  (REL)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .sdi (sdi),
        .busy (busy), .mode (mode), .cmd_en (cmd_en)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // frame of nbits; bits beyond the eighth are zero
    task automatic frame(input logic [7:0] op, input int nbits);
        @(negedge clk); cs_n = 1'b0;
        clks(4);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 8) ? op[7-i] : 1'b0;
            clks(2); sck = 1'b1;
            clks(2); sck = 1'b0;
        end
        clks(3);
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic settle(input int n);
        clks(n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        clks(5);
        chk("R1 reset mode", mode, M_SB);
        chk("R1 reset cmd_en", cmd_en, 2'b11);
        rst_n = 1'b1;
        clks(5);
        chk("R1 after release", mode, M_SB);

        // R2 active/standby rules
        @(negedge clk); cs_n = 1'b0; clks(4);
        chk("R2 cs low active", mode, M_ACT);
        @(negedge clk); cs_n = 1'b1; clks(4);
        chk("R2 cs high standby", mode, M_SB);
        busy = 1'b1; clks(1);
        chk("R2 busy active", mode, M_ACT);
        busy = 1'b0; clks(1);
        chk("R2 busy low standby", mode, M_SB);

        // R5 exact entry timing
        frame(DP, 8);
        repeat (DLY + 2) @(posedge clk); #1;
        chk("R5 not yet deep", mode, M_SB);
        @(posedge clk); #1;
        chk("R5 deep on edge", mode, M_DEEP);
        chk("R6 cmd_en blocked", cmd_en, 2'b00);

        // R6 deep independent of cs and busy
        @(negedge clk); cs_n = 1'b0; busy = 1'b1; clks(6);
        chk("R6 deep with cs low busy", mode, M_DEEP);
        @(negedge clk); cs_n = 1'b1; busy = 1'b0; clks(6);

        // R8 release with wrong length
        frame(REL, 7); settle(10);
        chk("R8 short release ignored", mode, M_DEEP);
        frame(REL, 9); settle(10);
        chk("R8 long release ignored", mode, M_DEEP);

        // R7 release
        frame(REL, 8); settle(10);
        chk("R7 release standby", mode, M_SB);
        chk("R7 release cmd_en", cmd_en, 2'b11);

        // R4 / R11 frame length sweep
        for (int n = 0; n <= 12; n++) begin
            frame(DP, n); settle(DLY + 10);
            chk($sformatf("R4 len %0d", n), mode, (n == 8) ? M_DEEP : M_SB);
            if (n == 8) begin frame(REL, 8); settle(10); end
        end
        frame(8'hFF, 3); settle(5);
        frame(DP, 8); settle(DLY + 10);
        chk("R11 partial then full", mode, M_DEEP);

        // R8 opcode sweep in deep
        for (int op = 0; op < 256; op++) begin
            if (op[7:0] != REL) begin
                frame(op[7:0], 8); settle(6);
                chk($sformatf("R8 op %02h in deep", op), mode, M_DEEP);
                chk($sformatf("R6 op %02h cmd_en", op), cmd_en, 2'b00);
            end
        end
        frame(REL, 8); settle(10);
        chk("R7 exit after sweep", mode, M_SB);

        // R3 opcode sweep in standby
        for (int op = 0; op < 256; op++) begin
            frame(op[7:0], 8); settle(DLY + 10);
            chk($sformatf("R3 op %02h", op), mode, (op[7:0] == DP) ? M_DEEP : M_SB);
            if (op[7:0] == DP) begin frame(REL, 8); settle(10); end
        end

        // R9 busy rejection
        busy = 1'b1;
        frame(DP, 8); settle(DLY + 10);
        chk("R9 busy active not deep", mode, M_ACT);
        busy = 1'b0; settle(DLY + 10);
        chk("R9 no late entry", mode, M_SB);

        // R10 release cancels pending entry
        frame(DP, 8); settle(4);
        frame(REL, 8); settle(DLY + 20);
        chk("R10 pending cancelled", mode, M_SB);
        chk("R10 cmd_en", cmd_en, 2'b11);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule